// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Match Points

This block is one channel of a periodic timer bank. Once enabled, a 32-bit counter loads a programmable reload value and counts down by one on every tick. When it gets past zero it loads the reload value again and keeps going. The tick is either every bus-clock cycle or a slow external strobe (nominally 1 MHz). The strobe is brought into the bus clock domain and turned into a single-cycle enable on each of its rising edges.

Events can happen at three points in each period: two programmable match thresholds and zero. On every event the interrupt output changes level, and a one-cycle status-set strobe tells the enclosing bank to latch a sticky status bit for this channel. The reload value, both match thresholds and the count are written through per-register write strobes that share one data bus. They are read back on separate plain outputs. The enclosing bank owns the enable, tick-select and zero-interrupt control bits and drives them straight into the channel.

Top module: `dmatch_timer`

## Requirements
- R1: Synchronous reset clears the count, the reload value, both match values, the interrupt level and the status strobe to zero.
- R2: On the first cycle `en` is sampled high after being low, the count loads the reload value. After that, each tick moves the count from N to N-1, and from 0 back to the reload value.
- R3: With `ext_sel` high, a tick happens only once per rising edge of `ext_tick`. That tick moves the count on the third rising clock edge after `ext_tick` first goes high. Holding the strobe high for longer gives no more ticks. With `ext_sel` low, every clock cycle is a tick.
- R4: A match value that is greater than or equal to the reload value counts as zero. It produces no event at a nonzero count.
- R5: An event fires on the tick that brings the count to a nonzero effective match value. Because the count falls, the larger threshold fires before the smaller one. Two equal thresholds give a single event.
- R6: An event fires on the tick that brings the count to zero only if `ovf_ie` is high or either stored match value is zero.
- R7: Each event inverts `irq` and drives `sts_set` high for exactly one cycle. Both change on the same clock edge as the count transition that caused the event. Nothing else changes `irq`.
- R8: `cnt_rd` shows the live count while `en` is high and the reload value while `en` is low.
- R9: A count write while enabled replaces the count on the next edge and causes no event. A count write while disabled has no effect: after re-enabling, the count starts from the reload value.
- R10: Writing a nonzero reload while the stored reload is zero and `en` is high also loads the count with the written value. Any other reload write leaves the count alone.
- R11: While `en` is low, no events happen and `irq` holds its level. Enabling again restarts the count from the reload value.
- R12: While the stored reload is zero, ticks do not change the count and produce no events.
- R13: Priority on one edge, highest first: enable start, count write, reload start, tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable |
| ext_sel | input | 1 | 1: tick from the external strobe, 0: tick every clock |
| ovf_ie | input | 1 | Allow an event when the count reaches zero |
| ext_tick | input | 1 | External tick strobe, asynchronous |
| cnt_we | input | 1 | Count write strobe |
| reload_we | input | 1 | Reload write strobe |
| match0_we | input | 1 | First match write strobe |
| match1_we | input | 1 | Second match write strobe |
| wdata | input | W | Write data for all registers |
| cnt_rd | output | W | Count read value |
| reload_rd | output | W | Reload read value |
| match0_rd | output | W | First match read value |
| match1_rd | output | W | Second match read value |
| irq | output | 1 | Interrupt level, inverted on each event |
| sts_set | output | 1 | One-cycle status-set strobe per event |

## Verification
The bench targets the following cases:
- Match values at or above reload. A design that skipped the clamp would never fire at those values, or would fire at stale ones.
- Two equal thresholds. A design that checked each threshold separately would invert `irq` twice and leave no visible edge.
- The zero-event rule with `ovf_ie` low and one match value stored as zero. Getting it wrong silently drops or adds the wrap interrupt.
- Writes while disabled, a reload going from zero to nonzero while enabled, and the external strobe's synchronizer latency. A count write that leaks through while disabled, a counter that stays stuck after a zero reload, or a tick per held-high cycle would each show up as a count mismatch on the port.

// File: rtl/dmatch_timer.sv
module dmatch_timer #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ext_sel,
  input  logic         ovf_ie,
  input  logic         ext_tick,
  input  logic         cnt_we,
  input  logic         reload_we,
  input  logic         match0_we,
  input  logic         match1_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_rd,
  output logic [W-1:0] reload_rd,
  output logic [W-1:0] match0_rd,
  output logic [W-1:0] match1_rd,
  output logic         irq,
  output logic         sts_set
);

  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt, rel, m0, m1;
  logic         en_d;
  logic [SYNC:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], ext_tick};
  end

  wire ext_pulse = sh[SYNC-1] & ~sh[SYNC];
  wire tick      = ext_sel ? ext_pulse : 1'b1;

  wire start     = en & ~en_d;
  wire wr_cnt    = en & cnt_we;
  wire rel_start = en & reload_we & (rel == ZERO) & (wdata != ZERO);

  wire [W-1:0] eff0 = (m0 < rel) ? m0 : ZERO;
  wire [W-1:0] eff1 = (m1 < rel) ? m1 : ZERO;
  wire [W-1:0] nxt  = (cnt == ZERO) ? rel : cnt - 1'b1;

  wire zero_ok = ovf_ie | (m0 == ZERO) | (m1 == ZERO);
  wire hit     = (nxt == ZERO) ? zero_ok : ((nxt == eff0) | (nxt == eff1));
  wire advance = en & ~start & ~wr_cnt & ~rel_start & tick & (rel != ZERO);
  wire evt     = advance & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= ZERO;
      rel     <= ZERO;
      m0      <= ZERO;
      m1      <= ZERO;
      en_d    <= 1'b0;
      irq     <= 1'b0;
      sts_set <= 1'b0;
    end else begin
      en_d    <= en;
      sts_set <= evt;
      if (evt)       irq <= ~irq;
      if (reload_we) rel <= wdata;
      if (match0_we) m0  <= wdata;
      if (match1_we) m1  <= wdata;
      if (start)          cnt <= rel;
      else if (wr_cnt)    cnt <= wdata;
      else if (rel_start) cnt <= wdata;
      else if (advance)   cnt <= nxt;
    end
  end

  assign cnt_rd    = en ? cnt : rel;
  assign reload_rd = rel;
  assign match0_rd = m0;
  assign match1_rd = m1;

  p_sts_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    sts_set == (irq != $past(irq)));

  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !en_d) |=> (cnt == $past(rel)));

  p_off_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sts_set && $stable(irq)));

  p_zero_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (rel == ZERO && en && en_d && !cnt_we && !reload_we) |=> $stable(cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (en && en_d && tick && !cnt_we && !reload_we && cnt != ZERO && rel != ZERO)
      |=> (cnt == $past(cnt) - 1'b1));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_sel && sh[SYNC-1] && sh[SYNC]) |-> !tick);

endmodule

// File: tb/sim_dmatch_timer.sv
module sim_dmatch_timer;
  logic clk = 0, rst = 1;
  logic en = 0, ext_sel = 0, ovf_ie = 0, ext_tick = 0;
  logic cnt_we = 0, reload_we = 0, match0_we = 0, match1_we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] cnt_rd, reload_rd, match0_rd, match1_rd;
  logic irq, sts_set;

  always #5 clk = ~clk;

  dmatch_timer #(.W(32), .SYNC(2)) u0 (
    .clk(clk), .rst(rst), .en(en), .ext_sel(ext_sel), .ovf_ie(ovf_ie),
    .ext_tick(ext_tick), .cnt_we(cnt_we), .reload_we(reload_we),
    .match0_we(match0_we), .match1_we(match1_we), .wdata(wdata),
    .cnt_rd(cnt_rd), .reload_rd(reload_rd), .match0_rd(match0_rd),
    .match1_rd(match1_rd), .irq(irq), .sts_set(sts_set));

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [31:0] mc, mr, mm0, mm1;
  logic mirq, msts, men_d;
  logic [2:0] ms;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] eff(input logic [31:0] m, input logic [31:0] r);
    return (m < r) ? m : 32'd0;
  endfunction

  function automatic logic zero_ev(input logic ie, input logic [31:0] a, input logic [31:0] b);
    return ie || a == 0 || b == 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [31:0] nc, nx;
    logic ev, pulse;
    pulse = ms[1] & ~ms[2];
    nc = mc; ev = 0;
    if (en && !men_d) nc = mr;
    else if (en && cnt_we) nc = wdata;
    else if (en && reload_we && mr == 0 && wdata != 0) nc = wdata;
    else if (en && (ext_sel ? pulse : 1'b1) && mr != 0) begin
      nx = (mc == 0) ? mr : mc - 1;
      if (nx == 0) ev = zero_ev(ovf_ie, mm0, mm1);
      else ev = (nx == eff(mm0, mr)) || (nx == eff(mm1, mr));
      nc = nx;
    end
    if (reload_we) mr = wdata;
    if (match0_we) mm0 = wdata;
    if (match1_we) mm1 = wdata;
    men_d = en;
    ms = {ms[1:0], ext_tick};
    mirq = mirq ^ ev;
    msts = ev;
    mc = nc;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", cnt_rd, en ? mc : mr);
    chk(tag, "irq", {31'd0, irq}, {31'd0, mirq});
    chk(tag, "sts_set", {31'd0, sts_set}, {31'd0, msts});
  endtask

  task automatic wr(input int which, input logic [31:0] v, input string tag);
    wdata = v;
    case (which)
      0: cnt_we = 1;
      1: reload_we = 1;
      2: match0_we = 1;
      default: match1_we = 1;
    endcase
    step(tag);
    cnt_we = 0; reload_we = 0; match0_we = 0; match1_we = 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    logic [31:0] c0;
    int flips;
    logic irq0;
    void'($urandom(32'd4242));
    mc = 0; mr = 0; mm0 = 0; mm1 = 0; mirq = 0; msts = 0; men_d = 0; ms = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1", "count", cnt_rd, 0);
    chk("R1", "reload", reload_rd, 0);
    chk("R1", "match0", match0_rd, 0);
    chk("R1", "match1", match1_rd, 0);
    chk("R1", "irq", {31'd0, irq}, 0);
    chk("R1", "sts_set", {31'd0, sts_set}, 0);

    wr(1, 5, "R8"); wr(2, 3, "R5"); wr(3, 1, "R5");
    chk("R8", "disabled count shows reload", cnt_rd, 5);
    en = 1; step("R2");
    chk("R2", "count after enable", cnt_rd, 5);
    step("R2");
    chk("R2", "first decrement", cnt_rd, 4);
    run(20, "R5");

    wr(3, 9, "R4");
    irq0 = irq; flips = 0;
    for (int i = 0; i < 12; i++) begin step("R4"); if (sts_set) flips++; end
    chk("R4", "events in two periods, only match at 3", flips, 2);
    wr(3, 5, "R4"); run(12, "R4");

    wr(2, 0, "R6"); run(14, "R6");
    wr(2, 3, "R6"); run(8, "R6");
    ovf_ie = 1; run(14, "R6"); ovf_ie = 0;
    wr(2, 2, "R5"); wr(3, 2, "R5"); run(14, "R5");

    wr(0, 1, "R9"); run(4, "R9");
    en = 0; run(3, "R11");
    wr(0, 3, "R9");
    chk("R9", "disabled write ignored on read", cnt_rd, 5);
    c0 = {31'd0, irq};
    run(10, "R11");
    chk("R11", "irq held while disabled", {31'd0, irq}, c0);
    en = 1; step("R11");
    chk("R11", "restart from reload", cnt_rd, 5);

    en = 1; cnt_we = 1; reload_we = 0; wdata = 2; step("R13"); cnt_we = 0;
    en = 0; step("R13");
    en = 1; cnt_we = 1; wdata = 1; step("R13"); cnt_we = 0;
    chk("R13", "enable beats count write", cnt_rd, 5);

    wr(1, 0, "R12"); run(10, "R12");
    c0 = cnt_rd; run(5, "R12");
    chk("R12", "count frozen with zero reload", cnt_rd, c0);
    wr(1, 7, "R10");
    chk("R10", "start from new reload", cnt_rd, 7);
    run(5, "R10");
    wr(1, 9, "R10"); run(4, "R10");

    ext_sel = 1; run(3, "R3");
    c0 = cnt_rd;
    ext_tick = 1; step("R3"); step("R3");
    chk("R3", "no move before third edge", cnt_rd, c0);
    step("R3");
    chk("R3", "move on third edge", cnt_rd, c0 - 1);
    run(6, "R3");
    chk("R3", "held strobe gives one tick", cnt_rd, c0 - 1);
    ext_tick = 0;
    for (int i = 0; i < 40; i++) begin ext_tick = i[2]; step("R3"); end
    ext_tick = 0; ext_sel = 0; run(3, "R3");

    for (int i = 0; i < 5000; i++) begin
      int r;
      r = $urandom % 100;
      en = ($urandom % 50) != 0;
      if (($urandom % 40) == 0) ovf_ie = ~ovf_ie;
      if (($urandom % 200) == 0) ext_sel = ~ext_sel;
      ext_tick = ($urandom % 4) == 0;
      wdata = $urandom % 14;
      cnt_we = (r < 3); reload_we = (r >= 3 && r < 6);
      match0_we = (r >= 6 && r < 10); match1_we = (r >= 10 && r < 14);
      step("R2");
    end
    cnt_we = 0; reload_we = 0; match0_we = 0; match1_we = 0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule